// File: doc/BRIEF.md
# Thermal Threshold Interrupt Controller

The block watches a stream of 8-bit temperature codes and compares each accepted sample against four programmable rising levels and four programmable falling levels. When a code crosses a level upward or downward, a sticky status bit for that level and direction is set. One level-high interrupt output is the OR of every status bit that is also enabled. Software clears status bits by writing ones to a clear register whose bit layout is the same as the status layout. Reading status and writing that value straight back clears everything pending.

A fifth threshold drives a dedicated trip output with no software in the loop. A test override can replace the sensed code with a programmed code, so that crossings can be produced without heating the die. A small register port with address, write data, write strobe and combinational read data gives access to every setting. The code that was last accepted can be read back and also serves as the previous sample for edge detection.

Top module: `thermal_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq` and `trip` are low. The current code reads zero and acts as the previous sample.
- R2: The rising-level register (address 1) holds level i in bits [8i+7:8i] and reads back as written. Status bit i is set on an accepted sample whose code is at or above level i while the previous code was below it.
- R3: The falling-level register (address 2) uses the same byte packing. Status bit 16+i is set on an accepted sample whose code is at or below falling level i while the previous code was above it. A falling level of zero never sets its bit.
- R4: Status (address 4) is sticky. Writing to the clear register (address 5) clears each status bit whose write-data bit is one, using the same positions as status.
- R5: The enable register (address 3) has rise enables in bits [3:0] and fall enables in bits [19:16]. `irq` is high exactly when some status bit and its enable bit are both one. Status bits are recorded whether or not they are enabled.
- R6: If a clear write and a new crossing hit the same status bit in one cycle, the bit ends set.
- R7: Control bit 0 (address 0) is core enable. While it is zero, samples are ignored: no status bit is set and the current code does not change.
- R8: The trip level lives in bits [7:0] of address 6. `trip` is high while control bit 0 and control bit 1 are both set and the current code is at or above the trip level.
- R9: Emulation register (address 7): bit 0 is enable and bits [15:8] are a code. While enable is set, each accepted sample uses that code in place of the sensed code, both for comparisons and for readback.
- R10: Address 8 returns the last accepted code in bits [7:0] and is updated on each accepted sample.
- R11: A code that stays at or above a rising level after its bit is cleared does not set the bit again until it has dropped below that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| temp_code | input | 8 | Sensed temperature code |
| temp_valid | input | 1 | Marks `temp_code` as a new sample |
| irq | output | 1 | Level-high interrupt |
| trip | output | 1 | Hardware trip output |

## Verification
The hardest case to reach is a clear write and a new crossing on the same status bit in one clock. The bench raises the write strobe and the sample strobe on the same clock edge, after first dropping the code below level 0, so that the next sample crosses it. Edge detection depends on the previous accepted code. For that reason the stimulus is one sequence of samples whose order is planned so that each crossing, each non-crossing and the disabled falling level occur at a known point.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int CODE_W   = 8;
  localparam int NLVL     = 4;
  localparam int FALL_OFS = 16;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int EMUL_LSB = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 4'd0,
    A_RISE  = 4'd1,
    A_FALL  = 4'd2,
    A_INTEN = 4'd3,
    A_STAT  = 4'd4,
    A_CLR   = 4'd5,
    A_TRIP  = 4'd6,
    A_EMUL  = 4'd7,
    A_CUR   = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/thr_regs.sv
module thr_regs
  import thr_pkg::*;
#(
  parameter int CW  = CODE_W,
  parameter int NL  = NLVL,
  parameter int FO  = FALL_OFS,
  parameter int DW  = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              we,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     evt,
  input  logic [CW-1:0]     cur_code,
  output logic              core_en,
  output logic              trip_en,
  output logic [CW*NL-1:0]  rise_th,
  output logic [CW*NL-1:0]  fall_th,
  output logic [DW-1:0]     inten,
  output logic [DW-1:0]     status,
  output logic [CW-1:0]     trip_th,
  output logic              emul_en,
  output logic [CW-1:0]     emul_code
);
  localparam int PW = CW * NL;

  function automatic logic [DW-1:0] mk_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < NL; i++) begin
      m[i]      = 1'b1;
      m[FO + i] = 1'b1;
    end
    return m;
  endfunction
  localparam logic [DW-1:0] EVT_MASK = mk_mask();

  logic          core_q, core_d, tripen_q, tripen_d, emen_q, emen_d;
  logic [PW-1:0] rise_q, rise_d, fall_q, fall_d;
  logic [DW-1:0] inten_q, inten_d, stat_q, stat_d, clr_mask;
  logic [CW-1:0] trip_q, trip_d, emcode_q, emcode_d;

  always_comb begin
    core_d   = core_q;
    tripen_d = tripen_q;
    rise_d   = rise_q;
    fall_d   = fall_q;
    inten_d  = inten_q;
    trip_d   = trip_q;
    emen_d   = emen_q;
    emcode_d = emcode_q;
    clr_mask = '0;
    if (we) begin
      case (addr)
        A_CTRL:  begin core_d = wdata[0]; tripen_d = wdata[1]; end
        A_RISE:  rise_d  = wdata[PW-1:0];
        A_FALL:  fall_d  = wdata[PW-1:0];
        A_INTEN: inten_d = wdata & EVT_MASK;
        A_CLR:   clr_mask = wdata & EVT_MASK;
        A_TRIP:  trip_d  = wdata[CW-1:0];
        A_EMUL:  begin emen_d = wdata[0]; emcode_d = wdata[EMUL_LSB +: CW]; end
        default: ;
      endcase
    end
    stat_d = (stat_q & ~clr_mask) | (evt & EVT_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q   <= 1'b0;
      tripen_q <= 1'b0;
      rise_q   <= '0;
      fall_q   <= '0;
      inten_q  <= '0;
      stat_q   <= '0;
      trip_q   <= '0;
      emen_q   <= 1'b0;
      emcode_q <= '0;
    end else begin
      core_q   <= core_d;
      tripen_q <= tripen_d;
      rise_q   <= rise_d;
      fall_q   <= fall_d;
      inten_q  <= inten_d;
      stat_q   <= stat_d;
      trip_q   <= trip_d;
      emen_q   <= emen_d;
      emcode_q <= emcode_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  begin rdata[0] = core_q; rdata[1] = tripen_q; end
      A_RISE:  rdata[PW-1:0] = rise_q;
      A_FALL:  rdata[PW-1:0] = fall_q;
      A_INTEN: rdata = inten_q;
      A_STAT:  rdata = stat_q;
      A_TRIP:  rdata[CW-1:0] = trip_q;
      A_EMUL:  begin rdata[0] = emen_q; rdata[EMUL_LSB +: CW] = emcode_q; end
      A_CUR:   rdata[CW-1:0] = cur_code;
      default: rdata = '0;
    endcase
  end

  assign core_en   = core_q;
  assign trip_en   = tripen_q;
  assign rise_th   = rise_q;
  assign fall_th   = fall_q;
  assign inten     = inten_q;
  assign status    = stat_q;
  assign trip_th   = trip_q;
  assign emul_en   = emen_q;
  assign emul_code = emcode_q;

  // R4: a cleared bit with no competing event is zero afterwards
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=> ((stat_q & $past(clr_mask & ~evt)) == '0));

  // R6: a new event is always recorded, even against a clear
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & EVT_MASK) != '0) |=> ((stat_q & $past(evt & EVT_MASK)) == $past(evt & EVT_MASK)));
endmodule

// File: rtl/thr_detect.sv
module thr_detect
  import thr_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NL = NLVL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_valid,
  input  logic [CW-1:0]    sense_code,
  input  logic             core_en,
  input  logic             emul_en,
  input  logic [CW-1:0]    emul_code,
  input  logic [CW*NL-1:0] rise_th,
  input  logic [CW*NL-1:0] fall_th,
  output logic [NL-1:0]    rise_ev,
  output logic [NL-1:0]    fall_ev,
  output logic [CW-1:0]    cur_code
);
  logic [CW-1:0] cur_q, cur_d, eff;
  logic          take;

  assign eff  = emul_en ? emul_code : sense_code;
  assign take = sample_valid & core_en;

  for (genvar i = 0; i < NL; i++) begin : g_lvl
    logic [CW-1:0] rth, fth;
    assign rth        = rise_th[i*CW +: CW];
    assign fth        = fall_th[i*CW +: CW];
    assign rise_ev[i] = take && (cur_q < rth) && (eff >= rth);
    assign fall_ev[i] = take && (fth != '0) && (cur_q > fth) && (eff <= fth);
  end

  always_comb begin
    cur_d = cur_q;
    if (take) cur_d = eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

  assign cur_code = cur_q;

  // R10: current code only moves on an accepted sample
  a_r10_cur_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_valid && core_en) |=> $stable(cur_q));
endmodule

// File: rtl/thermal_irq_ctrl.sv
module thermal_irq_ctrl
  import thr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CODE_W-1:0] temp_code,
  input  logic              temp_valid,
  output logic              irq,
  output logic              trip
);
  logic [1:0]             rst_sync;
  logic                   srst_n;
  logic                   core_en, trip_en, emul_en;
  logic [CODE_W*NLVL-1:0] rise_th, fall_th;
  logic [DATA_W-1:0]      inten, status, evt;
  logic [CODE_W-1:0]      trip_th, emul_code, cur_code;
  logic [NLVL-1:0]        rise_ev, fall_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  thr_regs u_regs (
    .clk(clk), .rst_n(srst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
    .rdata(reg_rdata), .evt(evt), .cur_code(cur_code), .core_en(core_en),
    .trip_en(trip_en), .rise_th(rise_th), .fall_th(fall_th), .inten(inten),
    .status(status), .trip_th(trip_th), .emul_en(emul_en), .emul_code(emul_code)
  );

  thr_detect u_det (
    .clk(clk), .rst_n(srst_n), .sample_valid(temp_valid), .sense_code(temp_code),
    .core_en(core_en), .emul_en(emul_en), .emul_code(emul_code),
    .rise_th(rise_th), .fall_th(fall_th), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .cur_code(cur_code)
  );

  always_comb begin
    evt = '0;
    evt[NLVL-1:0]         = rise_ev;
    evt[FALL_OFS +: NLVL] = fall_ev;
  end

  assign irq  = |(status & inten);
  assign trip = core_en & trip_en & (cur_code >= trip_th);

  // R7: with core disabled no status bit appears
  a_r7_core_gate: assert property (@(posedge clk) disable iff (!srst_n)
    !core_en |=> ((status & ~$past(status)) == '0));

  // R5: interrupt needs a pending status bit
  a_r5_irq_source: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> (status != '0));

  // R8: trip never asserts with the trip enable off
  a_r8_trip_gate: assert property (@(posedge clk) disable iff (!srst_n)
    !trip_en |-> !trip);
endmodule

// File: tb/thermal_irq_ctrl_tb.sv
`timescale 1ns/1ps
module thermal_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic [31:0] reg_rdata;
  logic [7:0]  temp_code;
  logic        temp_valid;
  logic        irq, trip;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  thermal_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .temp_code(temp_code),
    .temp_valid(temp_valid), .irq(irq), .trip(trip)
  );

  // {sample code, expected status after it}; levels rise 20/40/60/80, fall 10/30/50/off
  localparam logic [39:0] VEC [0:7] = '{
    {8'd25, 32'h0000_0001},
    {8'd45, 32'h0000_0003},
    {8'd45, 32'h0000_0003},
    {8'd85, 32'h0000_000F},
    {8'd55, 32'h0000_000F},
    {8'd50, 32'h0004_000F},
    {8'd5,  32'h0007_000F},
    {8'd20, 32'h0007_000F}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic smp(input logic [7:0] c);
    @(negedge clk);
    temp_code = c; temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_we = 1'b0;
    temp_code = '0; temp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 trip", {31'd0, trip}, 32'd0);
    rd(4'd4, v); check("R1 status", v, 32'd0);
    rd(4'd8, v); check("R1 cur", v, 32'd0);
    rd(4'd0, v); check("R1 ctrl", v, 32'd0);

    wr(4'd0, 32'h1);
    wr(4'd1, 32'h503C_2814);
    wr(4'd2, 32'h0032_1E0A);
    wr(4'd3, 32'h000F_000F);
    rd(4'd1, v); check("R2 rise readback", v, 32'h503C_2814);

    // R2 R3 R10 sample table
    for (int k = 0; k < 8; k++) begin
      smp(VEC[k][39:32]);
      rd(4'd8, v); check("R10 cur", v, {24'd0, VEC[k][39:32]});
      rd(4'd4, v); check("R2/R3 status", v, VEC[k][31:0]);
    end
    check("R5 irq on", {31'd0, irq}, 32'd1);

    // R4 write back status value
    rd(4'd4, v);
    wr(4'd5, v);
    rd(4'd4, v); check("R4 cleared", v, 32'd0);
    check("R4 irq off", {31'd0, irq}, 32'd0);

    // R11 code held at level 0, no new rise
    smp(8'd20);
    rd(4'd4, v); check("R11 no retrigger", v, 32'd0);

    // R5 masked event recorded, irq low until enabled
    wr(4'd3, 32'h0);
    smp(8'd45);
    rd(4'd4, v); check("R5 masked status", v, 32'h2);
    check("R5 masked irq", {31'd0, irq}, 32'd0);
    wr(4'd3, 32'h2);
    check("R5 enabled irq", {31'd0, irq}, 32'd1);

    // R3 falls on L0 and L1
    smp(8'd10);
    rd(4'd4, v); check("R3 falls", v, 32'h0003_0002);

    // R6 clear and new rise on L0 in the same cycle
    @(negedge clk);
    reg_addr = 4'd5; reg_wdata = 32'hFFFF_FFFF; reg_we = 1'b1;
    temp_code = 8'd25; temp_valid = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; temp_valid = 1'b0;
    rd(4'd4, v); check("R6 event wins", v, 32'h1);

    // R7 core disabled
    wr(4'd0, 32'h0);
    smp(8'd99);
    rd(4'd8, v); check("R7 cur held", v, 32'd25);
    rd(4'd4, v); check("R7 status held", v, 32'h1);

    // R8 trip
    wr(4'd6, 32'd90);
    wr(4'd0, 32'h3);
    smp(8'd95);
    check("R8 trip high", {31'd0, trip}, 32'd1);
    rd(4'd4, v); check("R2 multi rise", v, 32'hF);
    smp(8'd80);
    check("R8 trip low below", {31'd0, trip}, 32'd0);
    wr(4'd0, 32'h1);
    smp(8'd95);
    check("R8 trip gated", {31'd0, trip}, 32'd0);

    // R9 emulation override
    wr(4'd7, 32'h0000_2101);
    rd(4'd8, v); check("R9 not before sample", v, 32'd95);
    smp(8'd200);
    rd(4'd8, v); check("R9 emul code", v, 32'd33);
    wr(4'd7, 32'h0);
    smp(8'd7);
    rd(4'd8, v); check("R9 emul off", v, 32'd7);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule